// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block is the card-side configuration logic of an add-in card on a plug-and-play ISA-style bus. Software selects a configuration register by writing its index to a fixed address port, then writes the register through a fixed write-data port. Register reads come back through a read port whose location software chooses. The block keeps the card-level state, which is one of Wait for Key, Sleep, Isolation or Config. It stores the Card Select Number (CSN), the read-port location and the logical device select. It also holds a banked register file for each logical device: the activate bit, the I/O range-check control, the I/O base addresses, the interrupt slots and the DMA slots.

The initiation key sequence is detected elsewhere and arrives as a one-cycle strobe. Resource bytes come from an external byte source that has a ready flag. The block pulses an advance output each time a resource byte is read, and pulses a pointer-reset output when a wake command matches. While a logical device is inactive and its range check is enabled, the block answers reads at that device's programmed I/O base with a fixed test pattern. Software uses this pattern to find address conflicts.

Top module: `pnp_card_cfg`

## Requirements
- R1: After synchronous reset the card state is Wait for Key (card_state encoding: 0 Wait for Key, 1 Sleep, 2 Isolation, 3 Config), every logical device is inactive, and no read is answered.
- R2: In Wait for Key, data-port writes and register-index writes (to address 0x0279) are ignored, and a key_match strobe moves the card to Sleep. In any other state key_match has no effect.
- R3: A write to register 0x03 (through data port 0x0A79) whose byte equals the CSN pulses res_ptr_reset in that cycle. In Sleep, such a write moves the card to Isolation if the byte is zero and to Config otherwise. A write that does not match changes nothing.
- R4: The read-port register (0x00) and the CSN register (0x06) accept writes only in Isolation or Config. The device select (0x07) and all per-device registers (0x30 and above) accept writes only in Config.
- R5: Writing register 0x02 in any state other than Wait for Key acts through three bits. Bit 0 restores every device register to its power-up value and keeps the CSN. Bit 1 returns the card to Wait for Key and keeps the CSN. Bit 2 clears the CSN. The register keeps no value and always reads 0.
- R6: A read is answered with the register selected by the index only when address bits [15:10] are zero, bits [9:2] equal the byte written to register 0x00, and the card is in Isolation or Config. Address bits [1:0] are not compared.
- R7: Register 0x05 reads {7'b0, res_ready}. Register 0x04 returns res_byte and pulses res_advance during the read.
- R8: Register 0x07 holds the logical device number, and a write of a value not below NUM_DEV is ignored. Registers 0x30 and above address the bank of the selected device only.
- R9: Register 0x30 bit 0 activates the selected device, which is shown on dev_active; bits [7:1] read 0.
- R10: Register 0x31 holds the check enable in bit 1 and the pattern select in bit 0; bits [7:2] read 0. A read at an address that equals a nonzero I/O base of a device that has the check enabled and is inactive returns 0x55 if the pattern bit is set and 0xAA if it is clear.
- R11: I/O base range i sits at 0x60+2i (high byte) and 0x61+2i (low byte). Interrupt slot j has its level (4 bits) at 0x70+2j and its type (2 bits) at 0x71+2j. DMA slot k is at 0x74+k, 3 bits. The power-up value is 0 everywhere except the DMA slots, which power up to 4 (no channel).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_match | input | 1 | One-cycle strobe from the initiation key detector |
| io_addr | input | 16 | Bus I/O address |
| io_wdata | input | 8 | Bus write data |
| io_wr | input | 1 | Bus write strobe, one cycle per access |
| io_rd | input | 1 | Bus read strobe |
| io_rdata | output | 8 | Read data, valid while io_rdata_en is high |
| io_rdata_en | output | 1 | The card drives the read data bus |
| res_byte | input | 8 | Next resource byte from the byte source |
| res_ready | input | 1 | The resource byte is valid |
| res_advance | output | 1 | Pulse: a resource byte was read |
| res_ptr_reset | output | 1 | Pulse: rewind the resource byte source |
| card_state | output | 2 | Current card state |
| dev_active | output | NUM_DEV | Activate bit of each logical device |

## Verification
The assertions assume that key_match is a single-cycle strobe and that io_wr and io_rd are never high in the same cycle. They also assume that each access lasts exactly one clock. The bench drives every access from a task that raises the strobe for one cycle, starting on a falling edge. It sends key_match only as a separate one-cycle pulse, and it never overlaps a read with a write. The range-check assertion allows register reads to take priority, so the bench keeps device bases clear of the read-port window.

// File: rtl/pnp_pkg.sv
package pnp_pkg;

    parameter int ADDR_W    = 16;
    parameter int IO_RANGES = 2;
    parameter int IRQ_SLOTS = 2;
    parameter int DMA_SLOTS = 2;
    parameter int DMA_W     = 3;

    localparam logic [ADDR_W-1:0] INDEX_PORT = ADDR_W'(16'h0279);
    localparam logic [ADDR_W-1:0] WDATA_PORT = ADDR_W'(16'h0A79);

    localparam logic [7:0] IX_RDPORT = 8'h00;
    localparam logic [7:0] IX_CTRL   = 8'h02;
    localparam logic [7:0] IX_WAKE   = 8'h03;
    localparam logic [7:0] IX_RES    = 8'h04;
    localparam logic [7:0] IX_STAT   = 8'h05;
    localparam logic [7:0] IX_CSN    = 8'h06;
    localparam logic [7:0] IX_LDN    = 8'h07;
    localparam logic [7:0] IX_DEVLO  = 8'h30;
    localparam logic [7:0] IX_ACT    = 8'h30;
    localparam logic [7:0] IX_RCHK   = 8'h31;
    localparam logic [7:0] IX_IOB    = 8'h60;
    localparam logic [7:0] IX_IRQ    = 8'h70;
    localparam logic [7:0] IX_DMA    = 8'h74;

    localparam logic [DMA_W-1:0] DMA_NONE = DMA_W'(4);
    localparam logic [7:0] PAT_SET   = 8'h55;
    localparam logic [7:0] PAT_CLEAR = 8'hAA;

    typedef enum logic [1:0] {
        ST_WAIT_KEY = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_ISOLATE  = 2'd2,
        ST_CONFIG   = 2'd3
    } card_st_e;

    typedef struct packed {
        logic index_wr;
        logic data_wr;
        logic rport_rd;
    } bus_hit_t;

    typedef struct packed {
        logic                                 active;
        logic                                 chk_en;
        logic                                 chk_pat;
        logic [IO_RANGES-1:0][15:0]           io_base;
        logic [IRQ_SLOTS-1:0][3:0]            irq_lvl;
        logic [IRQ_SLOTS-1:0][1:0]            irq_kind;
        logic [DMA_SLOTS-1:0][DMA_W-1:0]      dma_ch;
    } dev_regs_t;

    function automatic dev_regs_t dev_power_up();
        dev_regs_t r;
        r = '0;
        for (int k = 0; k < DMA_SLOTS; k++) r.dma_ch[k] = DMA_NONE;
        return r;
    endfunction

    function automatic logic [7:0] dev_read(dev_regs_t r, logic [7:0] ix);
        logic [7:0] v;
        v = 8'h00;
        if (ix == IX_ACT)  v = {7'b0, r.active};
        if (ix == IX_RCHK) v = {6'b0, r.chk_en, r.chk_pat};
        for (int i = 0; i < IO_RANGES; i++) begin
            if (ix == IX_IOB + 8'(2*i))     v = r.io_base[i][15:8];
            if (ix == IX_IOB + 8'(2*i + 1)) v = r.io_base[i][7:0];
        end
        for (int j = 0; j < IRQ_SLOTS; j++) begin
            if (ix == IX_IRQ + 8'(2*j))     v = {4'b0, r.irq_lvl[j]};
            if (ix == IX_IRQ + 8'(2*j + 1)) v = {6'b0, r.irq_kind[j]};
        end
        for (int k = 0; k < DMA_SLOTS; k++) begin
            if (ix == IX_DMA + 8'(k)) v = {{(8-DMA_W){1'b0}}, r.dma_ch[k]};
        end
        return v;
    endfunction

endpackage

// File: rtl/pnp_bus_decode.sv
module pnp_bus_decode
    import pnp_pkg::*;
(
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        rport,
    output bus_hit_t          hit
);
    localparam int UPPER_W = ADDR_W - 10;

    always_comb begin
        hit.index_wr = io_wr && (io_addr == INDEX_PORT);
        hit.data_wr  = io_wr && (io_addr == WDATA_PORT);
        hit.rport_rd = io_rd && (io_addr[ADDR_W-1:10] == UPPER_W'(0))
                             && (io_addr[9:2] == rport);
    end
endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl
    import pnp_pkg::*;
#(
    parameter int NUM_DEV = 2,
    localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_match,
    input  bus_hit_t         hit,
    input  logic [7:0]       wdata,
    output card_st_e         state,
    output logic [7:0]       index,
    output logic [7:0]       csn,
    output logic [SEL_W-1:0] sel,
    output logic [7:0]       rport,
    output logic             dev_wr,
    output logic             dev_clear,
    output logic             ptr_rewind
);
    logic data_ok;
    logic iso_or_cfg;
    logic ctrl_wr;
    logic wake_hit;

    always_comb begin
        data_ok    = hit.data_wr && (state != ST_WAIT_KEY);
        iso_or_cfg = (state == ST_ISOLATE) || (state == ST_CONFIG);
        ctrl_wr    = data_ok && (index == IX_CTRL);
        wake_hit   = data_ok && (index == IX_WAKE) && (wdata == csn);
        dev_clear  = ctrl_wr && wdata[0];
        dev_wr     = data_ok && (state == ST_CONFIG) && (index >= IX_DEVLO);
        ptr_rewind = wake_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WAIT_KEY;
            index <= 8'h00;
            csn   <= 8'h00;
            sel   <= '0;
            rport <= 8'h00;
        end else begin
            if (hit.index_wr && (state != ST_WAIT_KEY))
                index <= wdata;

            if ((state == ST_WAIT_KEY) && key_match)
                state <= ST_SLEEP;
            else if (ctrl_wr && wdata[1])
                state <= ST_WAIT_KEY;
            else if (wake_hit && (state == ST_SLEEP))
                state <= (wdata == 8'h00) ? ST_ISOLATE : ST_CONFIG;

            if (ctrl_wr && wdata[2])
                csn <= 8'h00;
            else if (data_ok && iso_or_cfg && (index == IX_CSN))
                csn <= wdata;

            if (data_ok && iso_or_cfg && (index == IX_RDPORT))
                rport <= wdata;

            if (data_ok && (state == ST_CONFIG) && (index == IX_LDN)
                && (32'(wdata) < NUM_DEV))
                sel <= SEL_W'(wdata);
        end
    end
endmodule

// File: rtl/pnp_dev_bank.sv
module pnp_dev_bank
    import pnp_pkg::*;
#(
    parameter int NUM_DEV = 2,
    localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr,
    input  logic [7:0]        ix,
    input  logic [7:0]        wdata,
    input  logic [SEL_W-1:0]  sel,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    output logic [7:0]        rd_val,
    output logic [NUM_DEV-1:0] active,
    output logic              chk_hit,
    output logic [7:0]        chk_data
);
    dev_regs_t              bank [NUM_DEV];
    logic [NUM_DEV-1:0]     dev_hit;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                bank[g] <= dev_power_up();
            end else if (wr && (sel == SEL_W'(g))) begin
                if (ix == IX_ACT)  bank[g].active <= wdata[0];
                if (ix == IX_RCHK) {bank[g].chk_en, bank[g].chk_pat} <= wdata[1:0];
                for (int i = 0; i < IO_RANGES; i++) begin
                    if (ix == IX_IOB + 8'(2*i))     bank[g].io_base[i][15:8] <= wdata;
                    if (ix == IX_IOB + 8'(2*i + 1)) bank[g].io_base[i][7:0]  <= wdata;
                end
                for (int j = 0; j < IRQ_SLOTS; j++) begin
                    if (ix == IX_IRQ + 8'(2*j))     bank[g].irq_lvl[j]  <= wdata[3:0];
                    if (ix == IX_IRQ + 8'(2*j + 1)) bank[g].irq_kind[j] <= wdata[1:0];
                end
                for (int k = 0; k < DMA_SLOTS; k++) begin
                    if (ix == IX_DMA + 8'(k)) bank[g].dma_ch[k] <= wdata[DMA_W-1:0];
                end
            end
        end

        always_comb begin
            dev_hit[g] = 1'b0;
            if (io_rd && bank[g].chk_en && !bank[g].active) begin
                for (int i = 0; i < IO_RANGES; i++) begin
                    if ((bank[g].io_base[i] != 16'h0000) &&
                        (io_addr == ADDR_W'(bank[g].io_base[i])))
                        dev_hit[g] = 1'b1;
                end
            end
        end

        assign active[g] = bank[g].active;
    end

    always_comb begin
        chk_hit  = |dev_hit;
        chk_data = 8'h00;
        for (int d = NUM_DEV - 1; d >= 0; d--) begin
            if (dev_hit[d])
                chk_data = bank[d].chk_pat ? PAT_SET : PAT_CLEAR;
        end
        rd_val = dev_read(bank[sel], ix);
    end
endmodule

// File: rtl/pnp_card_cfg.sv
module pnp_card_cfg
    import pnp_pkg::*;
#(
    parameter int NUM_DEV = 2,
    localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               key_match,
    input  logic [15:0]        io_addr,
    input  logic [7:0]         io_wdata,
    input  logic               io_wr,
    input  logic               io_rd,
    output logic [7:0]         io_rdata,
    output logic               io_rdata_en,
    input  logic [7:0]         res_byte,
    input  logic               res_ready,
    output logic               res_advance,
    output logic               res_ptr_reset,
    output logic [1:0]         card_state,
    output logic [NUM_DEV-1:0] dev_active
);
    bus_hit_t         hit;
    card_st_e         state_q;
    logic [7:0]       index_q;
    logic [7:0]       csn_q;
    logic [SEL_W-1:0] sel_q;
    logic [7:0]       rport_q;
    logic             dev_wr;
    logic             dev_clear;
    logic [7:0]       dev_val;
    logic             chk_hit;
    logic [7:0]       chk_data;
    logic             reg_hit;
    logic [7:0]       reg_val;

    pnp_bus_decode u_decode (
        .io_addr (ADDR_W'(io_addr)),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .rport   (rport_q),
        .hit     (hit)
    );

    pnp_card_ctrl #(.NUM_DEV(NUM_DEV)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .key_match  (key_match),
        .hit        (hit),
        .wdata      (io_wdata),
        .state      (state_q),
        .index      (index_q),
        .csn        (csn_q),
        .sel        (sel_q),
        .rport      (rport_q),
        .dev_wr     (dev_wr),
        .dev_clear  (dev_clear),
        .ptr_rewind (res_ptr_reset)
    );

    pnp_dev_bank #(.NUM_DEV(NUM_DEV)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .clear    (dev_clear),
        .wr       (dev_wr),
        .ix       (index_q),
        .wdata    (io_wdata),
        .sel      (sel_q),
        .io_rd    (io_rd),
        .io_addr  (ADDR_W'(io_addr)),
        .rd_val   (dev_val),
        .active   (dev_active),
        .chk_hit  (chk_hit),
        .chk_data (chk_data)
    );

    always_comb begin
        unique case (index_q)
            IX_STAT: reg_val = {7'b0, res_ready};
            IX_RES:  reg_val = res_byte;
            IX_CSN:  reg_val = csn_q;
            IX_LDN:  reg_val = 8'(sel_q);
            default: reg_val = (index_q >= IX_DEVLO) ? dev_val : 8'h00;
        endcase
        reg_hit     = hit.rport_rd &&
                      ((state_q == ST_ISOLATE) || (state_q == ST_CONFIG));
        io_rdata_en = reg_hit || chk_hit;
        io_rdata    = reg_hit ? reg_val : (chk_hit ? chk_data : 8'h00);
        res_advance = reg_hit && (index_q == IX_RES);
        card_state  = state_q;
    end
endmodule

// File: rtl/pnp_card_cfg_chk.sv
module pnp_card_cfg_chk #(
    parameter int NUM_DEV = 2,
    localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               key_match,
    input logic               io_rd,
    input logic [1:0]         card_state,
    input logic [7:0]         csn,
    input logic [SEL_W-1:0]   sel,
    input logic [NUM_DEV-1:0] dev_active,
    input logic               res_advance,
    input logic               chk_hit,
    input logic               reg_hit,
    input logic [7:0]         io_rdata
);
    AST_KEY_TO_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (card_state == 2'd0 && key_match) |=> (card_state == 2'd1)); // R2

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (card_state == 2'd0 && !key_match) |=> (card_state == 2'd0)); // R2

    AST_ISOLATE_FROM_SLEEP: assert property (@(posedge clk) disable iff (rst)
        $rose(card_state == 2'd2) |-> ($past(card_state) == 2'd1)); // R3

    AST_CSN_SET_STATE: assert property (@(posedge clk) disable iff (rst)
        (!$stable(csn) && csn != 8'h00) |->
        ($past(card_state) == 2'd2 || $past(card_state) == 2'd3)); // R4

    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (32'(sel) < NUM_DEV)); // R8

    AST_ACTIVATE_IN_CONFIG: assert property (@(posedge clk) disable iff (rst)
        ((dev_active & ~$past(dev_active)) != '0) |-> ($past(card_state) == 2'd3)); // R9

    AST_ADVANCE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        res_advance |-> io_rd); // R7

    AST_PATTERN_VALUE: assert property (@(posedge clk) disable iff (rst)
        (chk_hit && !reg_hit) |-> (io_rdata == 8'h55 || io_rdata == 8'hAA)); // R10
endmodule

bind pnp_card_cfg pnp_card_cfg_chk #(.NUM_DEV(NUM_DEV)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .key_match   (key_match),
    .io_rd       (io_rd),
    .card_state  (card_state),
    .csn         (csn_q),
    .sel         (sel_q),
    .dev_active  (dev_active),
    .res_advance (res_advance),
    .chk_hit     (chk_hit),
    .reg_hit     (reg_hit),
    .io_rdata    (io_rdata)
);

// File: tb/test_pnp_card_cfg.sv
`timescale 1ns/1ps
module test_pnp_card_cfg;
    localparam int NUM_DEV = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               key_match = 1'b0;
    logic [15:0]        io_addr = '0;
    logic [7:0]         io_wdata = '0;
    logic               io_wr = 1'b0;
    logic               io_rd = 1'b0;
    logic [7:0]         io_rdata;
    logic               io_rdata_en;
    logic [7:0]         res_byte = '0;
    logic               res_ready = 1'b0;
    logic               res_advance;
    logic               res_ptr_reset;
    logic [1:0]         card_state;
    logic [NUM_DEV-1:0] dev_active;

    int checks = 0;
    int errors = 0;
    logic       last_rewind;
    logic [7:0] rd_v;
    logic       rd_en;
    logic       rd_adv;

    localparam logic [15:0] RPORT_ADDR = 16'h0203;

    always #10 clk = ~clk;

    pnp_card_cfg #(.NUM_DEV(NUM_DEV)) i_pnp_card_cfg (
        .clk(clk), .rst(rst), .key_match(key_match),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
        .io_rdata(io_rdata), .io_rdata_en(io_rdata_en),
        .res_byte(res_byte), .res_ready(res_ready),
        .res_advance(res_advance), .res_ptr_reset(res_ptr_reset),
        .card_state(card_state), .dev_active(dev_active)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_index(logic [7:0] v);
        @(negedge clk);
        io_addr = 16'h0279; io_wdata = v; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_addr = '0;
    endtask

    task automatic wr_data(logic [7:0] v);
        @(negedge clk);
        io_addr = 16'h0A79; io_wdata = v; io_wr = 1'b1;
        #5 last_rewind = res_ptr_reset;
        @(negedge clk);
        io_wr = 1'b0; io_addr = '0;
    endtask

    task automatic wr_reg(logic [7:0] ix, logic [7:0] v);
        wr_index(ix);
        wr_data(v);
    endtask

    task automatic rd_io(logic [15:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #5;
        rd_v = io_rdata; rd_en = io_rdata_en; rd_adv = res_advance;
        @(negedge clk);
        io_rd = 1'b0; io_addr = '0;
    endtask

    task automatic pulse_key();
        @(negedge clk); key_match = 1'b1;
        @(negedge clk); key_match = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 state", card_state, 0);
        check("R1 active", dev_active, 0);
        rd_io(16'h0000);
        check("R1 no read", rd_en, 0);
    endtask

    task automatic t_key();
        wr_index(8'h03);
        wr_data(8'h00);
        check("R2 write ignored in wait", card_state, 0);
        check("R2 no rewind in wait", last_rewind, 0);
        pulse_key();
        check("R2 key to sleep", card_state, 1);
        pulse_key();
        check("R2 key ignored in sleep", card_state, 1);
    endtask

    task automatic t_wake_isolate();
        wr_index(8'h03);
        wr_data(8'h05);
        check("R3 mismatch state", card_state, 1);
        check("R3 mismatch rewind", last_rewind, 0);
        wr_data(8'h00);
        check("R3 match rewind", last_rewind, 1);
        check("R3 zero to isolation", card_state, 2);
    endtask

    task automatic t_isolation_writes();
        wr_reg(8'h00, 8'h80);
        wr_reg(8'h07, 8'h01);
        rd_io(RPORT_ADDR);
        check("R4 ldn blocked in isolation en", rd_en, 1);
        check("R4 ldn blocked in isolation", rd_v, 0);
        wr_reg(8'h06, 8'h07);
        rd_io(RPORT_ADDR);
        check("R4 csn in isolation", rd_v, 8'h07);
        rd_io(16'h0200);
        check("R6 low bits ignored", rd_v, 8'h07);
        rd_io(16'h0207);
        check("R6 other port", rd_en, 0);
        rd_io(16'h0603);
        check("R6 upper bits", rd_en, 0);
    endtask

    task automatic t_to_config();
        wr_reg(8'h02, 8'h02);
        check("R5 back to wait", card_state, 0);
        pulse_key();
        wr_reg(8'h03, 8'h07);
        check("R3 nonzero to config", card_state, 3);
        wr_index(8'h06);
        rd_io(RPORT_ADDR);
        check("R5 csn kept", rd_v, 8'h07);
    endtask

    task automatic t_resource();
        res_ready = 1'b0;
        wr_index(8'h05);
        rd_io(RPORT_ADDR);
        check("R7 status not ready", rd_v, 0);
        res_ready = 1'b1;
        rd_io(RPORT_ADDR);
        check("R7 status ready", rd_v, 1);
        check("R7 no advance on status", rd_adv, 0);
        res_byte = 8'hC3;
        wr_index(8'h04);
        rd_io(RPORT_ADDR);
        check("R7 resource byte", rd_v, 8'hC3);
        check("R7 advance", rd_adv, 1);
    endtask

    task automatic t_devices();
        wr_reg(8'h07, 8'h01);
        rd_io(RPORT_ADDR);
        check("R8 ldn set", rd_v, 1);
        wr_data(8'h02);
        rd_io(RPORT_ADDR);
        check("R8 ldn out of range ignored", rd_v, 1);
        wr_reg(8'h60, 8'h03);
        wr_reg(8'h61, 8'h40);
        wr_reg(8'h70, 8'h05);
        wr_reg(8'h71, 8'h03);
        wr_reg(8'h74, 8'h03);
        wr_index(8'h61); rd_io(RPORT_ADDR);
        check("R11 base low", rd_v, 8'h40);
        wr_index(8'h70); rd_io(RPORT_ADDR);
        check("R11 irq level", rd_v, 8'h05);
        wr_index(8'h71); rd_io(RPORT_ADDR);
        check("R11 irq type", rd_v, 8'h03);
        wr_index(8'h74); rd_io(RPORT_ADDR);
        check("R11 dma", rd_v, 8'h03);
        wr_reg(8'h07, 8'h00);
        wr_index(8'h60); rd_io(RPORT_ADDR);
        check("R8 bank0 base untouched", rd_v, 0);
        wr_index(8'h75); rd_io(RPORT_ADDR);
        check("R11 dma power-up none", rd_v, 8'h04);
        wr_reg(8'h07, 8'h01);
    endtask

    task automatic t_activate_check();
        wr_reg(8'h30, 8'hFF);
        rd_io(RPORT_ADDR);
        check("R9 activate readback", rd_v, 8'h01);
        check("R9 dev_active", dev_active, 2'b10);
        wr_data(8'h00);
        check("R9 deactivate", dev_active, 2'b00);
        wr_reg(8'h31, 8'hFF);
        rd_io(RPORT_ADDR);
        check("R10 check readback", rd_v, 8'h03);
        rd_io(16'h0340);
        check("R10 en pattern 55", rd_en, 1);
        check("R10 pattern 55", rd_v, 8'h55);
        wr_data(8'h02);
        rd_io(16'h0340);
        check("R10 pattern AA", rd_v, 8'hAA);
        rd_io(16'h0341);
        check("R10 other address", rd_en, 0);
        wr_reg(8'h30, 8'h01);
        rd_io(16'h0340);
        check("R10 silent while active", rd_en, 0);
        wr_data(8'h00);
    endtask

    task automatic t_control_bits();
        wr_reg(8'h02, 8'h01);
        check("R5 reset keeps state", card_state, 3);
        rd_io(RPORT_ADDR);
        check("R5 control reads 0", rd_v, 0);
        wr_index(8'h61); rd_io(RPORT_ADDR);
        check("R5 base restored", rd_v, 0);
        wr_index(8'h74); rd_io(RPORT_ADDR);
        check("R5 dma restored", rd_v, 8'h04);
        wr_index(8'h06); rd_io(RPORT_ADDR);
        check("R5 csn kept on device reset", rd_v, 8'h07);
        rd_io(16'h0340);
        check("R5 check cleared", rd_en, 0);
        wr_reg(8'h02, 8'h04);
        wr_index(8'h06); rd_io(RPORT_ADDR);
        check("R5 csn cleared", rd_v, 0);
    endtask

    task automatic t_index_in_wait();
        wr_reg(8'h02, 8'h02);
        check("R5 wait again", card_state, 0);
        wr_index(8'h03);
        pulse_key();
        check("R2 sleep", card_state, 1);
        wr_data(8'h02);
        check("R2 index write ignored in wait", card_state, 0);
    endtask

    initial begin
        t_reset();
        t_key();
        t_wake_isolate();
        t_isolation_writes();
        t_to_config();
        t_resource();
        t_devices();
        t_activate_check();
        t_control_bits();
        t_index_in_wait();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule